// File: doc/BRIEF.md
# Parallel Panel Frame Write Engine

This block sends one frame of pixel words to a command-mode display panel over an 8080-style parallel write bus with an active-low chip select, an active-low write strobe and a data bus. Each word goes through four timed phases: chip-select setup, strobe setup, strobe active and strobe hold. The length of each phase comes from a 4-bit count in a timing configuration word. Pixels arrive on a valid/ready stream. A frame starts only on an explicit software trigger, and a trigger that arrives while a frame is under way is dropped. After the last word's hold phase, a one-cycle done pulse fires and a sticky interrupt flag is set. Software clears the flag by writing 1 to it.

The controller has seven states. ST_IDLE waits for a trigger. It moves to ST_FETCH when the frame has words, or to ST_FINISH when the frame is empty. ST_FETCH holds pixel ready high and moves to ST_CS_SETUP when a word is accepted. ST_CS_SETUP moves to ST_WR_SETUP, then to ST_WR_ACTIVE, then to ST_WR_HOLD, each when its phase timer expires. ST_WR_HOLD moves back to ST_FETCH, or to ST_FINISH after the last word. ST_FINISH emits the done pulse and returns to ST_IDLE. From every state, clearing the enable bit forces a return to ST_IDLE on the next edge.

Top module: `i80_frame_tx`

## Requirements
- R1: While reset is held and directly after it, chip select and write strobe are high, and busy, done pulse, done interrupt and pixel ready are low.
- R2: The timing word holds these 4-bit counts. Bits 19:16 are the chip-select setup count C. Bits 15:12 are the strobe setup count S. Bits 11:8 are the strobe active count A. Bits 7:4 are the strobe hold count H. A count of n gives n+1 cycles. For each word, chip select is low for C+S+A+H+4 consecutive cycles. The strobe falls in the (C+S+3)-th of those cycles, stays low for A+1 cycles, and is low only while chip select is low.
- R3: A frame starts only on a trigger write whose data has bit 0 (trigger mode) and bit 1 (trigger command) both set, and only while timing bit 0 (enable) is set. Any other trigger write leaves the engine idle.
- R4: A trigger write that arrives while busy is ignored. It neither restarts the frame nor queues a second one.
- R5: Words are taken from the pixel stream in order. Pixel ready is high only between words, while chip select is high. The bus data equals the accepted word and stays stable for the whole chip-select-low window.
- R6: A frame sends exactly width × height words. The done pulse lasts one cycle and appears in the first cycle that chip select is high after the last word's hold phase.
- R7: The done interrupt is set by the done pulse and stays set. A clear write with data 1 clears it, and a clear write with data 0 does nothing. When a set and a clear fall in the same cycle, the set wins.
- R8: Clearing the enable bit during a frame returns the engine to idle on the next cycle. Chip select and strobe go high and no done pulse is produced.
- R9: A trigger with width or height equal to 0 produces the done pulse in the cycle after the trigger, with no bus write.
- R10: The phase counts, width and height are captured when the trigger is accepted. Changing them during the frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timing | input | 20 | Phase counts (bits 19:4) and enable (bit 0) |
| cfg_width | input | DIM_W | Words per line |
| cfg_height | input | DIM_W | Lines per frame |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 2 | Trigger data: bit 0 mode, bit 1 command |
| irq_clr_we | input | 1 | Interrupt clear write strobe |
| irq_clr_wdata | input | 1 | Write 1 to clear the done interrupt |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream word |
| pix_ready | output | 1 | Pixel stream ready |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DATA_W | Panel data bus |
| busy | output | 1 | A frame is in progress |
| done_pulse | output | 1 | One-cycle end-of-frame event |
| done_irq | output | 1 | Sticky done interrupt |

## Verification
The bench builds the engine with DATA_W = 16 and DIM_W = 8. A 16-bit word gives every word of a frame its own distinct value, so a dropped or repeated word shows up on the bus. Frames are kept to a few lines, which keeps runs short while still allowing every phase count from 0 to 15. Directed frames cover all-zero counts, all-maximum counts, empty frames, a trigger during a busy frame, configuration changes in the middle of a frame, an enable drop during a frame, and a clear that collides with the done pulse. Random frames add stream stalls and mixed phase counts.

// File: rtl/i80_tx_pkg.sv
package i80_tx_pkg;

    localparam int PH_W          = 4;
    localparam int TIMING_W      = 20;
    localparam int EN_BIT        = 0;
    localparam int HOLD_LSB      = 4;
    localparam int ACTIVE_LSB    = 8;
    localparam int WSETUP_LSB    = 12;
    localparam int CSSETUP_LSB   = 16;
    localparam int TRIG_MODE_BIT = 0;
    localparam int TRIG_CMD_BIT  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CS_SETUP,
        ST_WR_SETUP,
        ST_WR_ACTIVE,
        ST_WR_HOLD,
        ST_FINISH
    } wr_state_t;

    typedef struct packed {
        logic [PH_W-1:0] cs_setup;
        logic [PH_W-1:0] wr_setup;
        logic [PH_W-1:0] wr_active;
        logic [PH_W-1:0] wr_hold;
    } phase_cfg_t;

    function automatic phase_cfg_t unpack_timing(input logic [TIMING_W-1:0] word);
        phase_cfg_t p;
        p.cs_setup  = word[CSSETUP_LSB +: PH_W];
        p.wr_setup  = word[WSETUP_LSB  +: PH_W];
        p.wr_active = word[ACTIVE_LSB  +: PH_W];
        p.wr_hold   = word[HOLD_LSB    +: PH_W];
        return p;
    endfunction

    function automatic logic [PH_W-1:0] phase_len(input wr_state_t st, input phase_cfg_t p);
        logic [PH_W-1:0] len;
        unique case (st)
            ST_CS_SETUP:  len = p.cs_setup;
            ST_WR_SETUP:  len = p.wr_setup;
            ST_WR_ACTIVE: len = p.wr_active;
            ST_WR_HOLD:   len = p.wr_hold;
            default:      len = '0;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/i80_phase_timer.sv
module i80_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/i80_word_counter.sv
module i80_word_counter #(
    parameter int DIM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             word_done,
    output logic             last_word
);

    localparam int TOT_W = 2 * DIM_W;

    logic [TOT_W-1:0] remain_q;
    logic [TOT_W-1:0] total;

    assign total = TOT_W'(width) * TOT_W'(height);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= total;
        end else if (word_done && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last_word = (remain_q == TOT_W'(1));

endmodule

// File: rtl/i80_done_flag.sv
module i80_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/i80_frame_tx.sv
module i80_frame_tx
    import i80_tx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int DIM_W  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIMING_W-1:0] cfg_timing,
    input  logic [DIM_W-1:0]    cfg_width,
    input  logic [DIM_W-1:0]    cfg_height,
    input  logic                trig_we,
    input  logic [1:0]          trig_wdata,
    input  logic                irq_clr_we,
    input  logic                irq_clr_wdata,
    input  logic                pix_valid,
    input  logic [DATA_W-1:0]   pix_data,
    output logic                pix_ready,
    output logic                lcd_cs_n,
    output logic                lcd_wr_n,
    output logic [DATA_W-1:0]   lcd_data,
    output logic                busy,
    output logic                done_pulse,
    output logic                done_irq
);

    wr_state_t        state_q, state_d;
    phase_cfg_t       shadow_q;
    logic             eng_en;
    logic             trig_go;
    logic             start_frame;
    logic             frame_empty;
    logic             timer_load;
    logic [PH_W-1:0]  timer_len;
    logic             timer_expire;
    logic             word_done;
    logic             last_word;
    logic             take_pixel;
    logic [DATA_W-1:0] data_q;

    assign eng_en      = cfg_timing[EN_BIT];
    assign trig_go     = trig_we && trig_wdata[TRIG_MODE_BIT] && trig_wdata[TRIG_CMD_BIT];
    assign start_frame = (state_q == ST_IDLE) && eng_en && trig_go;
    assign frame_empty = (cfg_width == '0) || (cfg_height == '0);
    assign take_pixel  = (state_q == ST_FETCH) && pix_valid && eng_en;
    assign word_done   = (state_q == ST_WR_HOLD) && timer_expire && eng_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_frame) state_d = frame_empty ? ST_FINISH : ST_FETCH;
            ST_FETCH:     if (pix_valid) state_d = ST_CS_SETUP;
            ST_CS_SETUP:  if (timer_expire) state_d = ST_WR_SETUP;
            ST_WR_SETUP:  if (timer_expire) state_d = ST_WR_ACTIVE;
            ST_WR_ACTIVE: if (timer_expire) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   if (timer_expire) state_d = last_word ? ST_FINISH : ST_FETCH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (!eng_en) begin
            state_d = ST_IDLE;
        end
    end

    // configuration snapshot taken at trigger acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (start_frame) begin
            shadow_q <= unpack_timing(cfg_timing);
        end
    end

    // data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take_pixel) begin
            data_q <= pix_data;
        end
    end

    assign timer_load = (state_d != state_q);
    assign timer_len  = phase_len(state_d, shadow_q);

    i80_phase_timer #(
        .CNT_W (PH_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .len    (timer_len),
        .expire (timer_expire)
    );

    i80_word_counter #(
        .DIM_W (DIM_W)
    ) u_words (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_frame),
        .width     (cfg_width),
        .height    (cfg_height),
        .word_done (word_done),
        .last_word (last_word)
    );

    i80_done_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done_pulse),
        .clr   (irq_clr_we && irq_clr_wdata),
        .flag  (done_irq)
    );

    // output decode
    always_comb begin
        lcd_cs_n   = 1'b1;
        lcd_wr_n   = 1'b1;
        pix_ready  = 1'b0;
        done_pulse = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_FETCH:     pix_ready = 1'b1;
            ST_CS_SETUP:  lcd_cs_n = 1'b0;
            ST_WR_SETUP:  lcd_cs_n = 1'b0;
            ST_WR_ACTIVE: begin
                lcd_cs_n = 1'b0;
                lcd_wr_n = 1'b0;
            end
            ST_WR_HOLD:   lcd_cs_n = 1'b0;
            ST_FINISH:    done_pulse = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    assign lcd_data = data_q;

endmodule

// File: rtl/i80_frame_tx_chk.sv
module i80_frame_tx_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [19:0]       cfg_timing,
    input logic              busy,
    input logic              lcd_cs_n,
    input logic              lcd_wr_n,
    input logic [DATA_W-1:0] lcd_data,
    input logic              pix_ready,
    input logic              done_pulse,
    input logic              done_irq
);

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (lcd_cs_n && lcd_wr_n)); // R1
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) !lcd_wr_n |-> !lcd_cs_n); // R2
    AST_READY_OUTSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) pix_ready |-> lcd_cs_n); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_data)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_pulse |=> !done_pulse); // R6
    AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) done_pulse |=> done_irq); // R7
    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n) !cfg_timing[0] |=> !busy); // R8

endmodule

bind i80_frame_tx i80_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_timing (cfg_timing),
    .busy       (busy),
    .lcd_cs_n   (lcd_cs_n),
    .lcd_wr_n   (lcd_wr_n),
    .lcd_data   (lcd_data),
    .pix_ready  (pix_ready),
    .done_pulse (done_pulse),
    .done_irq   (done_irq)
);

// File: tb/i80_frame_tx_test.sv
module i80_frame_tx_test;

    localparam int DW = 16;
    localparam int DIMW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [19:0]     cfg_timing = '0;
    logic [DIMW-1:0] cfg_width = '0;
    logic [DIMW-1:0] cfg_height = '0;
    logic            trig_we = 1'b0;
    logic [1:0]      trig_wdata = '0;
    logic            irq_clr_we = 1'b0;
    logic            irq_clr_wdata = 1'b0;
    logic            pix_valid = 1'b0;
    logic [DW-1:0]   pix_data = '0;
    logic            pix_ready;
    logic            lcd_cs_n;
    logic            lcd_wr_n;
    logic [DW-1:0]   lcd_data;
    logic            busy;
    logic            done_pulse;
    logic            done_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DW-1:0] px_base = '0;
    int            px_idx = 0;
    bit            src_on = 0;
    bit            hs_pend = 0;
    int            g_words = 0;

    always #2.5 clk = ~clk;

    i80_frame_tx #(.DATA_W(DW), .DIM_W(DIMW)) uut (.*);

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // pixel source with random stalls
    initial begin
        forever begin
            @(negedge clk);
            if (hs_pend) px_idx++;
            pix_valid = src_on && (($urandom % 4) != 0);
            pix_data  = px_base + DW'(px_idx);
            hs_pend   = pix_valid && pix_ready;
        end
    end

    task automatic run_frame(input int c, input int s, input int a, input int hh,
                             input int w, input int h, input bit retrig,
                             input bit change, input bit clr_at_done, input string ttag);
        int total = w * h;
        int words = 0, dones = 0, lowcnt = 0, wrlow = 0, wrfall = 0;
        bit t_ok = 1, d_ok = 1, prev_cs = 1;
        longint t_act = 0, t_exp = 0, d_act = 0, d_exp = 0;
        logic [DW-1:0] expd;
        @(negedge clk);
        cfg_timing = {4'(c), 4'(s), 4'(a), 4'(hh), 3'b000, 1'b1};
        cfg_width  = DIMW'(w);
        cfg_height = DIMW'(h);
        px_base    = DW'($urandom);
        px_idx     = 0;
        src_on     = 1;
        @(negedge clk);
        trig_we = 1; trig_wdata = 2'b11;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            trig_we = 0; irq_clr_we = 0;
            if (retrig && cyc == 3) begin trig_we = 1; trig_wdata = 2'b11; end
            if (change && cyc == 2) begin
                cfg_timing[19:4] = 16'($urandom);
                cfg_width  = DIMW'($urandom % 5);
                cfg_height = DIMW'($urandom % 5);
            end
            if (!lcd_cs_n) begin
                lowcnt++;
                expd = px_base + DW'(words);
                if (lcd_data !== expd && d_ok) begin d_ok = 0; d_act = lcd_data; d_exp = expd; end
                if (!lcd_wr_n) begin
                    wrlow++;
                    if (wrlow == 1) wrfall = lowcnt;
                end
            end else if (!prev_cs) begin
                if (t_ok && (lowcnt != c+s+a+hh+4 || wrfall != c+s+3 || wrlow != a+1)) begin
                    t_ok = 0;
                    t_act = lowcnt * 10000 + wrfall * 100 + wrlow;
                    t_exp = (c+s+a+hh+4) * 10000 + (c+s+3) * 100 + (a+1);
                end
                words++; lowcnt = 0; wrlow = 0; wrfall = 0;
            end
            prev_cs = lcd_cs_n;
            if (done_pulse) begin
                dones++;
                check(words == total, "R6", "words before done", words, total);
                if (clr_at_done) begin irq_clr_we = 1; irq_clr_wdata = 1; end
                break;
            end
        end
        @(negedge clk);
        if (clr_at_done) check(done_irq == 1'b1, "R7", "set wins over clear", done_irq, 1);
        irq_clr_we = 0; trig_we = 0;
        check(t_ok, ttag, "phase timing", t_act, t_exp);
        check(d_ok, "R5", "bus data", d_act, d_exp);
        check(dones == 1, "R6", "done pulses", dones, 1);
        g_words = words;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, retrig ? "R4" : "R6", "idle after frame", busy, 0);
        src_on = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(lcd_cs_n && lcd_wr_n && !busy && !done_irq && !pix_ready && !done_pulse, "R1", "in reset", 0, 1);
        rst_n = 1;
        @(negedge clk);
        check(lcd_cs_n && lcd_wr_n && !busy && !done_irq && !pix_ready, "R1", "after reset", 0, 1);

        // trigger gating, R3
        cfg_timing = 20'h11111; cfg_width = 2; cfg_height = 2;
        @(negedge clk); trig_we = 1; trig_wdata = 2'b01;
        @(negedge clk); trig_we = 0;
        check(!busy && lcd_cs_n, "R3", "mode bit only", busy, 0);
        trig_we = 1; trig_wdata = 2'b10;
        @(negedge clk); trig_we = 0;
        check(!busy && lcd_cs_n, "R3", "command bit only", busy, 0);
        cfg_timing[0] = 0; trig_we = 1; trig_wdata = 2'b11;
        @(negedge clk); trig_we = 0;
        check(!busy && lcd_cs_n, "R3", "engine disabled", busy, 0);

        run_frame(0, 0, 0, 0, 2, 2, 0, 0, 0, "R2");
        check(g_words == 4, "R3", "full trigger starts frame", g_words, 4);
        run_frame(15, 15, 15, 15, 1, 2, 0, 0, 0, "R2");
        run_frame(3, 1, 2, 1, 0, 3, 0, 0, 0, "R2");
        check(g_words == 0, "R9", "empty frame writes", g_words, 0);
        run_frame(2, 0, 4, 1, 3, 0, 0, 0, 0, "R2");
        check(g_words == 0, "R9", "zero height writes", g_words, 0);
        run_frame(2, 1, 3, 1, 3, 2, 1, 0, 0, "R2");
        check(g_words == 6, "R4", "words with retrigger", g_words, 6);
        run_frame(1, 2, 1, 2, 2, 3, 0, 1, 0, "R10");
        check(g_words == 6, "R10", "words after config change", g_words, 6);

        // R7 sticky interrupt and write-1-to-clear
        run_frame(0, 1, 0, 1, 1, 1, 0, 0, 0, "R2");
        check(done_irq == 1'b1, "R7", "sticky after frame", done_irq, 1);
        irq_clr_we = 1; irq_clr_wdata = 0;
        @(negedge clk); irq_clr_we = 0;
        check(done_irq == 1'b1, "R7", "clear with 0", done_irq, 1);
        irq_clr_we = 1; irq_clr_wdata = 1;
        @(negedge clk); irq_clr_we = 0;
        check(done_irq == 1'b0, "R7", "clear with 1", done_irq, 0);
        run_frame(1, 0, 1, 0, 1, 2, 0, 0, 1, "R2");

        // R8 abort by disable
        irq_clr_we = 1; irq_clr_wdata = 1;
        @(negedge clk); irq_clr_we = 0;
        cfg_timing = 20'hFFFF1; cfg_width = 4; cfg_height = 4;
        px_idx = 0; src_on = 1;
        @(negedge clk); trig_we = 1; trig_wdata = 2'b11;
        @(negedge clk); trig_we = 0;
        repeat (10) @(negedge clk);
        cfg_timing[0] = 0;
        @(negedge clk);
        check(!busy && lcd_cs_n && lcd_wr_n, "R8", "idle after disable", busy, 0);
        begin
            int dseen = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done_pulse || busy) dseen++;
            end
            check(dseen == 0 && !done_irq, "R8", "no done after abort", dseen, 0);
        end
        src_on = 0;

        // random frames
        for (int f = 0; f < 14; f++) begin
            run_frame(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                      int'($urandom % 16), int'($urandom % 4), int'(1 + $urandom % 3),
                      bit'($urandom % 2), 0, 0, "R2");
        end
        summary();
    end

endmodule